// File: doc/BRIEF.md
# Counted Buffer Transfer Engine

This block runs one counted data transfer between a storage device and a host, pacing it through a small byte buffer (512 bytes by default). Software writes a single control word that carries a byte count, a direction, a data width and a few mode flags, together with a start bit. The engine then alternates between two phases. In the device phase the device side strobes bytes or halfwords into or out of the buffer. In the host phase the host side empties or refills the buffer one 32-bit word at a time.

Each time a buffer window is ready for the host, the engine raises a one-cycle buffer-available event. A read window is ready once it has been filled. A write window is ready once it is empty. A window holds the smaller of the buffer size and the bytes still to go, so the last window may be partial. When the final byte has passed, a one-cycle done event fires. A device fault stops the transfer and raises an error event. Software can abort a running transfer at any time by writing the control word with the start bit low.

Top module: `xfer_engine`

## Requirements
- R1: A control write with bit 31 = 1 while the engine is not busy starts a transfer. The write loads the count from bits 17:0 and the flags from bit 30 (direction, 1 = host to device), bit 28 (DMA), bit 27 (I/O), bit 26 (attribute memory), bit 25 (width, 1 = 16-bit) and bit 24 (address increment off). These fields read back at the same positions; bits 29 and 23:18 read 0.
- R2: Readback bit 31 is 1 exactly while a transfer is busy. It reads 0 after done, after an error and after an abort. Bits 17:0 show the bytes still to pass on the device side.
- R3: dev_ready is 1 only in the device phase. Each dev_stb in that phase moves 2 bytes in 16-bit width and 1 byte in 8-bit width, and lowers the count by that amount, saturating at 0. A dev_stb outside the device phase has no effect.
- R4: Read transfer: the device fills a window of min(remaining, buffer size) bytes. Then evt_buf_avail pulses for one cycle and the host reads the window word by word with host_rd. After that the next window starts, and the last window may be partial.
- R5: Write transfer: evt_buf_avail pulses on the start edge and again each time the device has emptied a window while bytes remain. The host fills each window word by word with host_wr.
- R6: evt_done pulses for one cycle when the last byte has passed: taken by the host on a read, taken by the device on a write. The engine is then idle.
- R7: A control write with bit 31 = 0 while busy stops the transfer on that edge. No done or buffer event follows it.
- R8: dev_fault while busy stops the transfer and pulses evt_err for one cycle. This takes priority over a same-cycle abort. dev_fault while not busy has no effect.
- R9: host_rd and host_wr outside the host phase, or against the active direction, are ignored. host_rdata reads 0 unless a read transfer is in its host phase. dev_rdata reads 0 unless a write transfer is in its device phase.
- R10: Byte order: the lowest buffer byte of a host word sits in bits 7:0. A 16-bit device transfer carries its first byte in bits 7:0. Bytes of a word beyond the window read as 0.
- R11: A start with count 0 pulses evt_done on the start edge and moves no data.
- R12: A control write with bit 31 = 1 while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_rdata | output | 32 | Control word readback |
| host_wr | input | 1 | Host word write into the buffer |
| host_wdata | input | 8*HOST_BYTES | Host write data |
| host_rd | input | 1 | Host word read from the buffer |
| host_rdata | output | 8*HOST_BYTES | Host read data at the current position |
| dev_stb | input | 1 | Device byte/halfword strobe |
| dev_wdata | input | 16 | Data from the device (read transfers) |
| dev_rdata | output | 16 | Data to the device (write transfers) |
| dev_ready | output | 1 | Device phase active |
| dev_fault | input | 1 | Device-side fault |
| evt_buf_avail | output | 1 | Window ready for the host |
| evt_done | output | 1 | Count exhausted |
| evt_err | output | 1 | Transfer stopped by a fault |

## Verification
The bench builds the engine with a 32-byte buffer and 4-byte host words. With these values, counts of a few dozen bytes already span several windows and end in partial windows of odd length. Both widths, both directions, aborts, faults and zero counts all fit in a short run. A larger count limit or buffer changes only the lengths of the windows, not the sequencing that this setting exercises.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_ACTIVE   = 2'd1,
    ST_WAIT_BUF = 2'd2,
    ST_DONE     = 2'd3
  } xfer_state_e;

  localparam int B_START = 31;
  localparam int B_DIR   = 30;
  localparam int B_DMA   = 28;
  localparam int B_IO    = 27;
  localparam int B_ATTR  = 26;
  localparam int B_WIDE  = 25;
  localparam int B_NOINC = 24;

  typedef struct packed {
    logic dir;
    logic dma;
    logic io;
    logic attr;
    logic wide;
    logic noinc;
  } xfer_mode_t;
endpackage

// File: rtl/xfer_regs.sv
module xfer_regs
  import xfer_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [31:0]      ctrl_wdata,
  input  logic             busy,
  output logic             load,
  output logic             abort,
  output logic [CNT_W-1:0] ld_count,
  output xfer_mode_t       ld_mode,
  output xfer_mode_t       mode
);
  assign load     = ctrl_we && ctrl_wdata[B_START] && !busy;
  assign abort    = ctrl_we && !ctrl_wdata[B_START] && busy;
  assign ld_count = ctrl_wdata[CNT_W-1:0];

  always_comb begin
    ld_mode.dir   = ctrl_wdata[B_DIR];
    ld_mode.dma   = ctrl_wdata[B_DMA];
    ld_mode.io    = ctrl_wdata[B_IO];
    ld_mode.attr  = ctrl_wdata[B_ATTR];
    ld_mode.wide  = ctrl_wdata[B_WIDE];
    ld_mode.noinc = ctrl_wdata[B_NOINC];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode <= '0;
    else if (load) mode <= ld_mode;
  end
endmodule

// File: rtl/xfer_fsm.sv
module xfer_fsm
  import xfer_pkg::*;
#(
  parameter int BUF_BYTES  = 512,
  parameter int CNT_W      = 18,
  parameter int HOST_BYTES = 4,
  localparam int PTR_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             ld_dir,
  input  logic [CNT_W-1:0] ld_count,
  input  logic             abort,
  input  logic             fault,
  input  logic             dir,
  input  logic             wide,
  input  logic             dev_stb,
  input  logic             host_wr,
  input  logic             host_rd,
  output xfer_state_e      state,
  output logic [CNT_W-1:0] rem,
  output logic [PTR_W-1:0] win,
  output logic [PTR_W-1:0] hptr,
  output logic [PTR_W-1:0] dptr,
  output logic             dev_ok,
  output logic             host_ok,
  output logic             ev_avail,
  output logic             ev_done,
  output logic             ev_err
);
  localparam int SUM_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] BUF_CNT = CNT_W'(BUF_BYTES);

  xfer_state_e      state_n;
  logic [CNT_W-1:0] rem_n, rem_after;
  logic [PTR_W-1:0] win_n, hptr_n, dptr_n;
  logic             av_n, dn_n, er_n, busy;
  logic [1:0]       step;
  logic [SUM_W-1:0] dsum, hsum;

  function automatic logic [PTR_W-1:0] win_of(input logic [CNT_W-1:0] c);
    return (c > BUF_CNT) ? PTR_W'(BUF_BYTES) : PTR_W'(c);
  endfunction

  assign busy      = (state == ST_ACTIVE) || (state == ST_WAIT_BUF);
  assign dev_ok    = dev_stb && (state == ST_ACTIVE);
  assign host_ok   = (state == ST_WAIT_BUF) && (dir ? host_wr : host_rd);
  assign step      = wide ? 2'd2 : 2'd1;
  assign rem_after = (rem > CNT_W'(step)) ? rem - CNT_W'(step) : '0;
  assign dsum      = SUM_W'(dptr) + SUM_W'(step);
  assign hsum      = SUM_W'(hptr) + SUM_W'(HOST_BYTES);

  always_comb begin
    state_n = state;
    rem_n   = rem;
    win_n   = win;
    hptr_n  = hptr;
    dptr_n  = dptr;
    av_n    = 1'b0;
    dn_n    = 1'b0;
    er_n    = 1'b0;
    case (state)
      ST_IDLE, ST_DONE: begin
        state_n = ST_IDLE;
        if (load) begin
          rem_n  = ld_count;
          win_n  = win_of(ld_count);
          hptr_n = '0;
          dptr_n = '0;
          if (ld_count == '0) begin
            state_n = ST_DONE;
            dn_n    = 1'b1;
          end else if (ld_dir) begin
            state_n = ST_WAIT_BUF;
            av_n    = 1'b1;
          end else begin
            state_n = ST_ACTIVE;
          end
        end
      end
      ST_ACTIVE: begin
        if (dev_ok) begin
          rem_n  = rem_after;
          dptr_n = PTR_W'(dsum);
          if (dsum >= SUM_W'(win)) begin
            dptr_n = '0;
            hptr_n = '0;
            if (dir && rem_after == '0) begin
              state_n = ST_DONE;
              dn_n    = 1'b1;
            end else begin
              state_n = ST_WAIT_BUF;
              av_n    = 1'b1;
              if (dir) win_n = win_of(rem_after);
            end
          end
        end
      end
      ST_WAIT_BUF: begin
        if (host_ok) begin
          hptr_n = PTR_W'(hsum);
          if (hsum >= SUM_W'(win)) begin
            hptr_n = '0;
            dptr_n = '0;
            if (!dir && rem == '0) begin
              state_n = ST_DONE;
              dn_n    = 1'b1;
            end else begin
              state_n = ST_ACTIVE;
              if (!dir) win_n = win_of(rem);
            end
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
    if (busy && fault) begin
      state_n = ST_IDLE;
      av_n    = 1'b0;
      dn_n    = 1'b0;
      er_n    = 1'b1;
    end else if (busy && abort) begin
      state_n = ST_IDLE;
      av_n    = 1'b0;
      dn_n    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rem      <= '0;
      win      <= '0;
      hptr     <= '0;
      dptr     <= '0;
      ev_avail <= 1'b0;
      ev_done  <= 1'b0;
      ev_err   <= 1'b0;
    end else begin
      state    <= state_n;
      rem      <= rem_n;
      win      <= win_n;
      hptr     <= hptr_n;
      dptr     <= dptr_n;
      ev_avail <= av_n;
      ev_done  <= dn_n;
      ev_err   <= er_n;
    end
  end
endmodule

// File: rtl/xfer_buf.sv
module xfer_buf #(
  parameter int BUF_BYTES  = 512,
  parameter int HOST_BYTES = 4,
  localparam int PTR_W     = $clog2(BUF_BYTES + 1),
  localparam int SUM_W     = PTR_W + 1
) (
  input  logic                    clk,
  input  logic                    host_we,
  input  logic                    host_re,
  input  logic [8*HOST_BYTES-1:0] host_wdata,
  input  logic [PTR_W-1:0]        hptr,
  input  logic                    dev_we,
  input  logic                    dev_re,
  input  logic                    wide,
  input  logic [15:0]             dev_wdata,
  input  logic [PTR_W-1:0]        dptr,
  input  logic [PTR_W-1:0]        win,
  output logic [8*HOST_BYTES-1:0] host_rdata,
  output logic [15:0]             dev_rdata
);
  logic [8*BUF_BYTES-1:0] flat;

  for (genvar b = 0; b < BUF_BYTES; b++) begin : g_byte
    logic [7:0]       q, d;
    logic             we;
    logic [SUM_W-1:0] hoff;
    always_comb begin
      we   = 1'b0;
      d    = dev_wdata[7:0];
      hoff = SUM_W'(b) - SUM_W'(hptr);
      if (host_we && SUM_W'(b) >= SUM_W'(hptr) && hoff < SUM_W'(HOST_BYTES)) begin
        we = 1'b1;
        d  = 8'(host_wdata >> {hoff, 3'b000});
      end else if (dev_we && SUM_W'(b) == SUM_W'(dptr)) begin
        we = 1'b1;
      end else if (dev_we && wide && SUM_W'(b) == SUM_W'(dptr) + 1'b1) begin
        we = 1'b1;
        d  = dev_wdata[15:8];
      end
    end
    always_ff @(posedge clk) begin
      if (we) q <= d;
    end
    assign flat[8*b +: 8] = q;
  end

  for (genvar i = 0; i < HOST_BYTES; i++) begin : g_hrd
    logic [SUM_W-1:0] idx;
    assign idx = SUM_W'(hptr) + SUM_W'(i);
    assign host_rdata[8*i +: 8] = (host_re && idx < SUM_W'(win)) ?
                                  8'(flat >> {idx, 3'b000}) : 8'h00;
  end

  logic [SUM_W-1:0] didx_hi;
  assign didx_hi        = SUM_W'(dptr) + 1'b1;
  assign dev_rdata[7:0] = dev_re ? 8'(flat >> {SUM_W'(dptr), 3'b000}) : 8'h00;
  assign dev_rdata[15:8] = (dev_re && wide && didx_hi < SUM_W'(win)) ?
                           8'(flat >> {didx_hi, 3'b000}) : 8'h00;
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import xfer_pkg::*;
#(
  parameter int BUF_BYTES  = 512,
  parameter int CNT_W      = 18,
  parameter int HOST_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ctrl_we,
  input  logic [31:0]             ctrl_wdata,
  output logic [31:0]             ctrl_rdata,
  input  logic                    host_wr,
  input  logic [8*HOST_BYTES-1:0] host_wdata,
  input  logic                    host_rd,
  output logic [8*HOST_BYTES-1:0] host_rdata,
  input  logic                    dev_stb,
  input  logic [15:0]             dev_wdata,
  output logic [15:0]             dev_rdata,
  output logic                    dev_ready,
  input  logic                    dev_fault,
  output logic                    evt_buf_avail,
  output logic                    evt_done,
  output logic                    evt_err
);
  localparam int PTR_W = $clog2(BUF_BYTES + 1);
  localparam int PAD_W = 24 - CNT_W;

  logic [1:0]       rst_sync;
  logic             rst_i;
  logic             busy, load, abort, dev_ok, host_ok;
  logic [CNT_W-1:0] ld_count, rem;
  logic [PTR_W-1:0] win, hptr, dptr;
  xfer_mode_t       ld_mode, mode;
  xfer_state_e      state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  assign busy = (state == ST_ACTIVE) || (state == ST_WAIT_BUF);

  xfer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_i), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .busy(busy), .load(load), .abort(abort), .ld_count(ld_count),
    .ld_mode(ld_mode), .mode(mode)
  );

  xfer_fsm #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W), .HOST_BYTES(HOST_BYTES)) u_fsm (
    .clk(clk), .rst_n(rst_i), .load(load), .ld_dir(ld_mode.dir),
    .ld_count(ld_count), .abort(abort), .fault(dev_fault), .dir(mode.dir),
    .wide(mode.wide), .dev_stb(dev_stb), .host_wr(host_wr), .host_rd(host_rd),
    .state(state), .rem(rem), .win(win), .hptr(hptr), .dptr(dptr),
    .dev_ok(dev_ok), .host_ok(host_ok), .ev_avail(evt_buf_avail),
    .ev_done(evt_done), .ev_err(evt_err)
  );

  xfer_buf #(.BUF_BYTES(BUF_BYTES), .HOST_BYTES(HOST_BYTES)) u_buf (
    .clk(clk),
    .host_we(host_ok && mode.dir),
    .host_re((state == ST_WAIT_BUF) && !mode.dir),
    .host_wdata(host_wdata), .hptr(hptr),
    .dev_we(dev_ok && !mode.dir),
    .dev_re((state == ST_ACTIVE) && mode.dir),
    .wide(mode.wide), .dev_wdata(dev_wdata), .dptr(dptr), .win(win),
    .host_rdata(host_rdata), .dev_rdata(dev_rdata)
  );

  assign dev_ready  = (state == ST_ACTIVE);
  assign ctrl_rdata = {busy, mode.dir, 1'b0, mode.dma, mode.io, mode.attr,
                       mode.wide, mode.noinc, {PAD_W{1'b0}}, rem};
endmodule

// File: rtl/xfer_engine_chk.sv
module xfer_engine_chk #(
  parameter int HOST_BYTES = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ctrl_we,
  input logic [31:0]             ctrl_wdata,
  input logic [31:0]             ctrl_rdata,
  input logic [8*HOST_BYTES-1:0] host_rdata,
  input logic [15:0]             dev_rdata,
  input logic                    dev_ready,
  input logic                    dev_fault,
  input logic                    evt_buf_avail,
  input logic                    evt_done,
  input logic                    evt_err
);
  assert_events_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({evt_buf_avail, evt_done, evt_err}) <= 1);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> !evt_done);

  assert_done_clears_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> !ctrl_rdata[31]);

  assert_err_from_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |-> ($past(dev_fault) && !ctrl_rdata[31]));

  assert_abort_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !ctrl_wdata[31] && ctrl_rdata[31])
      |=> (!ctrl_rdata[31] && !evt_done && !evt_buf_avail));

  assert_ready_when_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ready |-> ctrl_rdata[31]);

  assert_idle_data_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[31] |-> (host_rdata == '0 && dev_rdata == '0));
endmodule

bind xfer_engine xfer_engine_chk #(.HOST_BYTES(HOST_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
  .ctrl_rdata(ctrl_rdata), .host_rdata(host_rdata), .dev_rdata(dev_rdata),
  .dev_ready(dev_ready), .dev_fault(dev_fault), .evt_buf_avail(evt_buf_avail),
  .evt_done(evt_done), .evt_err(evt_err)
);

// File: tb/xfer_engine_test.sv
`timescale 1ns/1ps
module xfer_engine_test;
  localparam int BUF = 32;
  localparam int HB  = 4;
  localparam logic [31:0] START = 32'h8000_0000;
  localparam logic [31:0] WRDIR = 32'h4000_0000;
  localparam logic [31:0] WIDE  = 32'h0200_0000;
  localparam logic [31:0] MODES = 32'h1D00_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 1'b0, host_wr = 1'b0, host_rd = 1'b0, dev_stb = 1'b0, dev_fault = 1'b0;
  logic [31:0] ctrl_wdata = '0, host_wdata = '0;
  logic [15:0] dev_wdata = '0;
  logic [31:0] ctrl_rdata, host_rdata;
  logic [15:0] dev_rdata;
  logic dev_ready, evt_buf_avail, evt_done, evt_err;

  always #2 clk = ~clk;

  xfer_engine #(.BUF_BYTES(BUF), .HOST_BYTES(HB)) uut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .dev_stb(dev_stb),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_ready(dev_ready),
    .dev_fault(dev_fault), .evt_buf_avail(evt_buf_avail), .evt_done(evt_done),
    .evt_err(evt_err)
  );

  int compared = 0, mismatched = 0;
  bit cmp_on = 1'b0, ended = 1'b0;

  // behavioural reference: phase 0 idle, 1 device, 2 host, 3 done
  int ph, rem, win, hp, dp;
  bit m_dir, m_dma, m_io, m_attr, m_wide, m_noinc, e_av, e_dn, e_er;
  logic [7:0] mm [BUF];

  always @(posedge clk) begin : model
    int stp;
    bit busy;
    if (!rst_n) begin
      ph = 0; rem = 0; win = 0; hp = 0; dp = 0;
      {m_dir, m_dma, m_io, m_attr, m_wide, m_noinc} = '0;
      {e_av, e_dn, e_er} = '0;
    end else begin
      {e_av, e_dn, e_er} = '0;
      busy = (ph == 1) || (ph == 2);
      stp = m_wide ? 2 : 1;
      if (busy && dev_fault) begin
        ph = 0; e_er = 1;
      end else if (busy && ctrl_we && !ctrl_wdata[31]) begin
        ph = 0;
      end else if (ph == 0 || ph == 3) begin
        ph = 0;
        if (ctrl_we && ctrl_wdata[31]) begin
          m_dir = ctrl_wdata[30]; m_dma = ctrl_wdata[28]; m_io = ctrl_wdata[27];
          m_attr = ctrl_wdata[26]; m_wide = ctrl_wdata[25]; m_noinc = ctrl_wdata[24];
          rem = int'(ctrl_wdata[17:0]);
          win = (rem > BUF) ? BUF : rem;
          hp = 0; dp = 0;
          if (rem == 0) begin ph = 3; e_dn = 1; end
          else if (m_dir) begin ph = 2; e_av = 1; end
          else ph = 1;
        end
      end else if (ph == 1) begin
        if (dev_stb) begin
          if (!m_dir) begin
            mm[dp] = dev_wdata[7:0];
            if (m_wide && dp + 1 < BUF) mm[dp+1] = dev_wdata[15:8];
          end
          rem = (rem > stp) ? rem - stp : 0;
          dp = dp + stp;
          if (dp >= win) begin
            dp = 0; hp = 0;
            if (m_dir && rem == 0) begin ph = 3; e_dn = 1; end
            else begin
              ph = 2; e_av = 1;
              if (m_dir) win = (rem > BUF) ? BUF : rem;
            end
          end
        end
      end else begin
        if (m_dir ? host_wr : host_rd) begin
          if (m_dir)
            for (int i = 0; i < HB; i++)
              if (hp + i < BUF) mm[hp+i] = host_wdata[8*i +: 8];
          hp = hp + HB;
          if (hp >= win) begin
            hp = 0; dp = 0;
            if (!m_dir && rem == 0) begin ph = 3; e_dn = 1; end
            else begin
              ph = 1;
              if (!m_dir) win = (rem > BUF) ? BUF : rem;
            end
          end
        end
      end
    end
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at %0t: actual %h expected %h", tag, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin : compare
    logic [31:0] xc, xh;
    logic [15:0] xd;
    bit busy;
    if (cmp_on) begin
      busy = (ph == 1) || (ph == 2);
      xc = {busy, m_dir, 1'b0, m_dma, m_io, m_attr, m_wide, m_noinc, 6'b0, rem[17:0]};
      xh = '0;
      if (ph == 2 && !m_dir)
        for (int i = 0; i < HB; i++)
          if (hp + i < win) xh[8*i +: 8] = mm[hp+i];
      xd = '0;
      if (ph == 1 && m_dir) begin
        xd[7:0] = mm[dp];
        if (m_wide && dp + 1 < win) xd[15:8] = mm[dp+1];
      end
      check("R2", "ctrl_rdata", ctrl_rdata, xc);
      check("R3", "dev_ready", {31'b0, dev_ready}, {31'b0, ph == 1});
      check("R4", "evt_buf_avail", {31'b0, evt_buf_avail}, {31'b0, e_av});
      check("R6", "evt_done", {31'b0, evt_done}, {31'b0, e_dn});
      check("R8", "evt_err", {31'b0, evt_err}, {31'b0, e_er});
      check("R10", "host_rdata", host_rdata, xh);
      check("R9", "dev_rdata", {16'b0, dev_rdata}, {16'b0, xd});
    end
  end

  logic [31:0] pat = 32'h1234_5678;

  task automatic cyc(bit we, logic [31:0] wd, bit hw, bit hr, bit ds, bit flt);
    @(negedge clk);
    pat = pat * 32'd1664525 + 32'd1013904223;
    ctrl_we = we; ctrl_wdata = wd; host_wr = hw; host_rd = hr;
    dev_stb = ds; dev_fault = flt;
    host_wdata = pat; dev_wdata = pat[23:8];
  endtask
  task automatic idle(int n);  for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, 0, 0); endtask
  task automatic ctl(logic [31:0] w); cyc(1, w, 0, 0, 0, 0); endtask
  task automatic devs(int n);  for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, 1, 0); endtask
  task automatic hrd(int n);   for (int i = 0; i < n; i++) cyc(0, '0, 0, 1, 0, 0); endtask
  task automatic hwr(int n);   for (int i = 0; i < n; i++) cyc(0, '0, 1, 0, 0, 0); endtask

  task automatic finish_run();
    ended = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!ended) begin
      mismatched++;
      $display("FAIL R6 watchdog expired: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    idle(4);
    // R1 R2: reset readback is all zero
    check("R1", "reset ctrl_rdata", ctrl_rdata, 32'h0);
    // R4 R3 R9: narrow read of 40 bytes, stray host reads and extra strobes ignored
    ctl(START | 32'd40); hrd(2); devs(32); devs(3); hrd(8); devs(8); hrd(2); idle(3);
    // R4 R10 R3: wide read of 70 bytes, final partial window of 6
    ctl(START | WIDE | 32'd70); devs(16); hrd(8); devs(16); hrd(8); devs(3); hrd(2); idle(3);
    // R5 R10: narrow write of 37 bytes, odd partial window
    ctl(START | WRDIR | 32'd37); devs(2); hwr(8); hrd(1); devs(32); hwr(2); devs(5); idle(3);
    // R1 R5: wide write of 64 bytes with every mode flag set
    ctl(START | WRDIR | WIDE | MODES | 32'd64); hwr(8); devs(16); hwr(8); devs(16); idle(3);
    // R3: wide write with odd count saturates the count at zero
    ctl(START | WRDIR | WIDE | 32'd5); hwr(2); devs(3); idle(3);
    // R7: abort in the middle of a read, later strobes ignored
    ctl(START | 32'd100); devs(10); ctl(32'h0); devs(3); hrd(2); idle(2);
    // R8: fault during a write host phase
    ctl(START | WRDIR | 32'd50); hwr(3); cyc(0, '0, 0, 0, 0, 1); idle(2);
    // R8: fault while idle has no effect
    cyc(0, '0, 0, 0, 0, 1); idle(2);
    // R8 R7: fault wins over a same-cycle abort
    ctl(START | 32'd20); devs(4); cyc(1, 32'h0, 0, 0, 0, 1); idle(2);
    // R11: zero count finishes immediately
    ctl(START | WRDIR | 32'd0); idle(3);
    // R12: restart attempt while busy is ignored
    ctl(START | 32'd20); devs(4); ctl(START | WRDIR | 32'd8); devs(16); hrd(5); idle(3);
    // R9: window accesses while idle are ignored
    hwr(2); hrd(2); devs(2); idle(2);
    finish_run();
  end
endmodule